// File: doc/BRIEF.md
# Pin Function and Output Register Block

This block holds the pin-muxing and output state for a bank of general-purpose pins behind a simple 32-bit register port. Every pin carries a 3-bit function code that picks between plain input, plain output and six alternate peripheral functions. Codes for ten pins share one 32-bit selector word. A pad multiplexer outside the block reads the code, the output enable and the output data for each pin.

Output data is never written directly. Software changes it with two write-only register pairs: one sets latch bits and the other clears them, so no read-modify-write is needed. A read-only level pair returns the synchronised pad inputs of all pins, whatever function each pin has. Pin-indexed registers use two 32-bit words: pin p sits in word p/32 at bit p%32.

Top module: `gpio_fsel_regs`

## Requirements
- R1: After reset every function code is 0 (input), every output latch is 0, `pad_oe_o` and `pad_out_o` are all 0, and every selector word reads back 0.
- R2: The selector word at byte offset 4*(p/10) holds pin p's code in bits [3*(p%10)+2 : 3*(p%10)]. The six words sit at offsets 0x00 to 0x14. A write to a word updates only the pins in that word. Read-back returns the stored codes, and bits with no pin behind them (bits 31:30, and bits 31:12 of the word at 0x14) read 0.
- R3: `pad_func_o[3p+2:3p]` equals pin p's stored code from the cycle after the selector write. `pad_oe_o[p]` is 1 exactly when that code is 1 (GPIO output). Code 0 is GPIO input, and codes 2 to 7 select alternate functions.
- R4: A write to offset 0x1C (pins 0-31) or 0x20 (pins 32-53) sets the output latch of each pin whose data bit is 1. Zero bits have no effect. The new latch value shows on `pad_out_o` in the cycle after the write.
- R5: A write to offset 0x28 (pins 0-31) or 0x2C (pins 32-53) clears the output latch of each pin whose data bit is 1. Zero bits have no effect.
- R6: A read of offset 0x34 (pins 0-31) or 0x38 (pins 32-53) returns `pad_in_i` after a two-flop synchroniser. A pad change applied before edge N shows up in a read whose request is sampled at edge N+2 or later. A read sampled at edge N+1 still returns the old value.
- R7: The output latch keeps its value while the pin's code is not 1. When the pin later switches to code 1, it drives the last value that was set or cleared.
- R8: Bits 31:22 of the words for pins 32-53 stand for no pin. They read 0 at offset 0x38, and writes to them at 0x20 and 0x2C change nothing.
- R9: Selector writes on consecutive cycles are each applied in the cycle after their own edge. When a pin goes from one alternate code to another through code 0, `pad_oe_o` stays 0 throughout, and it changes only in the cycle after a selector write.
- R10: Reads of the set and clear offsets, of unmapped offsets and of unaligned addresses return 0. Writes to unmapped offsets change no pin state.
- R11: `rdata_o` is registered. It updates in the cycle after a read request is sampled and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (8) | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pad_in_i | input | NUM_PINS (54) | Pad input levels, asynchronous |
| pad_func_o | output | NUM_PINS*3 (162) | Per-pin function code to the pad mux |
| pad_oe_o | output | NUM_PINS (54) | Per-pin output enable for GPIO output |
| pad_out_o | output | NUM_PINS (54) | Per-pin output latch value |

## Verification
Writes take effect at the edge that samples them, so `pad_func_o`, `pad_oe_o` and `pad_out_o` are checked on the falling edge right after each write. Read data is checked on the falling edge after the read request is sampled. Pad inputs go through two synchroniser flops, so the bench changes `pad_in_i` on a falling edge and waits one idle cycle before reading. It also runs one read a cycle early to confirm that the old level is still returned. The back-to-back selector sequence is sampled on every cycle so that the exact timing of `pad_oe_o` is checked.

// File: rtl/gpio_fsel_pkg.sv
package gpio_fsel_pkg;
  localparam int unsigned REG_W     = 32;
  // word indices (byte offset = 4 * index)
  localparam int unsigned SET_WORD  = 7;   // 0x1C
  localparam int unsigned CLR_WORD  = 10;  // 0x28
  localparam int unsigned LEV_WORD  = 13;  // 0x34

  localparam logic [2:0] FN_IN  = 3'd0;
  localparam logic [2:0] FN_OUT = 3'd1;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_FSEL,
    ACC_SET,
    ACC_CLR,
    ACC_LEV
  } acc_e;

  typedef struct packed {
    acc_e       kind;
    logic [7:0] idx;
  } acc_t;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_fsel_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FSEL_WORDS = 6,
  parameter int unsigned BANKS      = 2   // must stay <= 3 so ranges do not overlap
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_t              acc_o
);
  int unsigned word;
  logic        aligned;

  assign word    = 32'(addr_i) >> 2;
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    acc_o.kind = ACC_NONE;
    acc_o.idx  = '0;
    if (aligned) begin
      if (word < FSEL_WORDS) begin
        acc_o.kind = ACC_FSEL;
        acc_o.idx  = 8'(word);
      end else if (word >= SET_WORD && word < SET_WORD + BANKS) begin
        acc_o.kind = ACC_SET;
        acc_o.idx  = 8'(word - SET_WORD);
      end else if (word >= CLR_WORD && word < CLR_WORD + BANKS) begin
        acc_o.kind = ACC_CLR;
        acc_o.idx  = 8'(word - CLR_WORD);
      end else if (word >= LEV_WORD && word < LEV_WORD + BANKS) begin
        acc_o.kind = ACC_LEV;
        acc_o.idx  = 8'(word - LEV_WORD);
      end
    end
  end
endmodule

// File: rtl/gpio_fsel_file.sv
module gpio_fsel_file
  import gpio_fsel_pkg::*;
#(
  parameter int unsigned NUM_PINS      = 54,
  parameter int unsigned PINS_PER_WORD = 10,
  parameter int unsigned FSEL_W        = 3,
  localparam int unsigned FSEL_WORDS   = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD,
  localparam int unsigned USED_W       = PINS_PER_WORD * FSEL_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [7:0]                   widx_i,
  input  logic [REG_W-1:0]             wdata_i,
  output logic [NUM_PINS*FSEL_W-1:0]   fsel_o,
  output logic [FSEL_WORDS*REG_W-1:0]  words_o
);
  logic [NUM_PINS*FSEL_W-1:0] fsel_q;
  logic unused_hi;

  assign unused_hi = ^wdata_i[REG_W-1:USED_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PINS; p++) fsel_q[p*FSEL_W +: FSEL_W] <= FN_IN;
    end else if (wr_i) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (widx_i == 8'(p / PINS_PER_WORD))
          fsel_q[p*FSEL_W +: FSEL_W] <= wdata_i[(p % PINS_PER_WORD)*FSEL_W +: FSEL_W];
      end
    end
  end

  always_comb begin
    words_o = '0;
    for (int p = 0; p < NUM_PINS; p++)
      words_o[(p / PINS_PER_WORD)*REG_W + (p % PINS_PER_WORD)*FSEL_W +: FSEL_W] =
        fsel_q[p*FSEL_W +: FSEL_W];
  end

  assign fsel_o = fsel_q;
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_fsel_pkg::*;
#(
  parameter int unsigned NUM_PINS = 54
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic                clr_i,
  input  logic [7:0]          bank_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [NUM_PINS-1:0] lat_o
);
  logic [NUM_PINS-1:0] lat_q;

  // set and clear live at distinct addresses, so they never coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
    end else if (set_i || clr_i) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (bank_i == 8'(p / REG_W) && wdata_i[p % REG_W])
          lat_q[p] <= set_i;
      end
    end
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 54,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
  import gpio_fsel_pkg::*;
#(
  parameter int unsigned NUM_PINS      = 54,
  parameter int unsigned PINS_PER_WORD = 10,
  parameter int unsigned FSEL_W        = 3,
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rdata_o,
  input  logic [NUM_PINS-1:0]        pad_in_i,
  output logic [NUM_PINS*FSEL_W-1:0] pad_func_o,
  output logic [NUM_PINS-1:0]        pad_oe_o,
  output logic [NUM_PINS-1:0]        pad_out_o
);
  localparam int unsigned FSEL_WORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
  localparam int unsigned BANKS      = (NUM_PINS + REG_W - 1) / REG_W;
  localparam int unsigned LEV_W      = BANKS * REG_W;

  acc_t                        acc;
  logic                        wr, rd;
  logic [FSEL_WORDS*REG_W-1:0] fsel_words;
  logic [NUM_PINS*FSEL_W-1:0]  fsel;
  logic [NUM_PINS-1:0]         lat;
  logic [NUM_PINS-1:0]         lev_sync;
  logic [LEV_W-1:0]            lev_wide;
  logic [REG_W-1:0]            rd_next, rdata_q;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  gpio_addr_dec #(
    .ADDR_W     (ADDR_W),
    .FSEL_WORDS (FSEL_WORDS),
    .BANKS      (BANKS)
  ) u_dec (
    .addr_i (addr_i),
    .acc_o  (acc)
  );

  gpio_fsel_file #(
    .NUM_PINS      (NUM_PINS),
    .PINS_PER_WORD (PINS_PER_WORD),
    .FSEL_W        (FSEL_W)
  ) u_fsel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr && acc.kind == ACC_FSEL),
    .widx_i  (acc.idx),
    .wdata_i (wdata_i),
    .fsel_o  (fsel),
    .words_o (fsel_words)
  );

  gpio_out_latch #(
    .NUM_PINS (NUM_PINS)
  ) u_lat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (wr && acc.kind == ACC_SET),
    .clr_i   (wr && acc.kind == ACC_CLR),
    .bank_i  (acc.idx),
    .wdata_i (wdata_i),
    .lat_o   (lat)
  );

  gpio_in_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (lev_sync)
  );

  assign lev_wide = LEV_W'(lev_sync);

  always_comb begin
    rd_next = '0;
    unique case (acc.kind)
      ACC_FSEL: begin
        for (int w = 0; w < FSEL_WORDS; w++)
          if (acc.idx == 8'(w)) rd_next = fsel_words[w*REG_W +: REG_W];
      end
      ACC_LEV: begin
        for (int b = 0; b < BANKS; b++)
          if (acc.idx == 8'(b)) rd_next = lev_wide[b*REG_W +: REG_W];
      end
      default: rd_next = '0;  // set/clear are write-only
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    assign pad_oe_o[p] = (fsel[p*FSEL_W +: FSEL_W] == FN_OUT);
  end

  assign pad_func_o = fsel;
  assign pad_out_o  = lat;
endmodule

// File: rtl/gpio_fsel_regs_chk.sv
module gpio_fsel_regs_chk #(
  parameter int unsigned NUM_PINS   = 54,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FSEL_WORDS = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [31:0]         wdata_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_out_o
);
  localparam logic [ADDR_W-1:0] FSEL_END = ADDR_W'(FSEL_WORDS * 4);
  localparam logic [ADDR_W-1:0] SET_LO   = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] SET_HI   = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] CLR_LO   = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] CLR_HI   = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] LEV_HI   = ADDR_W'(8'h38);
  localparam logic [31:0] HI_UNUSED = ~((32'd1 << (NUM_PINS - 32)) - 32'd1);

  logic wr_fsel, wr_out, rd_any;
  assign wr_fsel = req_i && we_i && addr_i < FSEL_END;
  assign wr_out  = req_i && we_i &&
                   (addr_i == SET_LO || addr_i == SET_HI || addr_i == CLR_LO || addr_i == CLR_HI);
  assign rd_any  = req_i && !we_i;

  AST_OE_ONLY_AFTER_FSEL_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o != $past(pad_oe_o)) |-> $past(wr_fsel)); // R9

  AST_OUT_ONLY_AFTER_SETCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o != $past(pad_out_o)) |-> $past(wr_out)); // R7

  AST_SET_PIN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == SET_LO && wdata_i[0]) |=> pad_out_o[0]); // R4

  AST_CLR_PIN0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == CLR_LO && wdata_i[0]) |=> !pad_out_o[0]); // R5

  AST_HI_LEVEL_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_any && addr_i == LEV_HI) |=> ((rdata_o & HI_UNUSED) == 32'd0)); // R8

  AST_WRITE_ONLY_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_any && (addr_i == SET_LO || addr_i == CLR_LO)) |=> (rdata_o == 32'd0)); // R10

  AST_RDATA_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_any |=> $stable(rdata_o)); // R11
endmodule

bind gpio_fsel_regs gpio_fsel_regs_chk #(
  .NUM_PINS   (NUM_PINS),
  .ADDR_W     (ADDR_W),
  .FSEL_WORDS (FSEL_WORDS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pad_oe_o  (pad_oe_o),
  .pad_out_o (pad_out_o)
);

// File: tb/tb_gpio_fsel_regs.sv
`timescale 1ns/1ps
module tb_gpio_fsel_regs;
  localparam int NP = 54;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          req_i = 0, we_i = 0;
  logic [7:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NP-1:0] pad_in_i = '0;
  logic [NP*3-1:0] pad_func_o;
  logic [NP-1:0] pad_oe_o, pad_out_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [NP*3-1:0] m_func = '0;
  logic [NP-1:0]   m_lat = '0;
  logic [31:0]     seed = 32'h1234_5678;

  always #2.5 clk_i = ~clk_i;

  gpio_fsel_regs dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pad_in_i, .pad_func_o, .pad_oe_o, .pad_out_o
  );

  task automatic chk(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i); req_i = 0; d = rdata_o;
  endtask

  function automatic void model_fsel(input int w, input logic [31:0] d);
    for (int i = 0; i < 10; i++)
      if (w*10 + i < NP) m_func[(w*10+i)*3 +: 3] = d[i*3 +: 3];
  endfunction

  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] v = '0;
    for (int i = 0; i < 10; i++)
      if (w*10 + i < NP) v[i*3 +: 3] = m_func[(w*10+i)*3 +: 3];
    return v;
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = (m_func[p*3 +: 3] == 3'd1);
    return v;
  endfunction

  function automatic void model_setclr(input bit set, input int bank, input logic [31:0] d);
    for (int i = 0; i < 32; i++)
      if (bank*32 + i < NP && d[i]) m_lat[bank*32+i] = set;
  endfunction

  task automatic chk_pads(input string tag);
    chk(pad_func_o == m_func, {tag, " func"}, 192'(pad_func_o), 192'(m_func));
    chk(pad_oe_o == exp_oe(), {tag, " oe"}, 192'(pad_oe_o), 192'(exp_oe()));
    chk(pad_out_o == m_lat, {tag, " out"}, 192'(pad_out_o), 192'(m_lat));
  endtask

  task automatic chk_words(input string tag);
    logic [31:0] r;
    for (int w = 0; w < 6; w++) begin
      rd(8'(w*4), r);
      chk(r == exp_word(w), tag, 192'(r), 192'(exp_word(w)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, d;
    logic [NP-1:0] v, old;

    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    @(negedge clk_i);
    chk_pads("R1 reset");
    chk_words("R1 reset word");

    // R2/R3 sweep every code in every word, unused bits set in the write
    for (int w = 0; w < 6; w++) begin
      for (int c = 0; c < 8; c++) begin
        d = 32'hC000_0000;
        for (int i = 0; i < 10; i++) d[i*3 +: 3] = 3'(c);
        wr(8'(w*4), d);
        model_fsel(w, d);
        chk_pads("R3 code sweep");
        rd(8'(w*4), r);
        chk(r == exp_word(w), "R2 readback", 192'(r), 192'(exp_word(w)));
      end
    end

    // R2 mixed patterns
    for (int k = 0; k < 20; k++) begin
      for (int w = 0; w < 6; w++) begin
        d = rnd();
        wr(8'(w*4), d);
        model_fsel(w, d);
      end
      chk_pads("R3 random codes");
      chk_words("R2 random readback");
    end

    // all pins to output for set/clear
    for (int w = 0; w < 6; w++) begin
      wr(8'(w*4), 32'h0924_9249);
      model_fsel(w, 32'h0924_9249);
    end
    chk_pads("R3 all out");

    // R4 walking set, R5 walking clear
    for (int p = 0; p < NP; p++) begin
      wr(p < 32 ? 8'h1C : 8'h20, 32'd1 << (p % 32));
      m_lat[p] = 1'b1;
      chk(pad_out_o == m_lat, "R4 set walk", 192'(pad_out_o), 192'(m_lat));
    end
    wr(8'h1C, 32'd0);
    chk(pad_out_o == m_lat, "R4 zero write", 192'(pad_out_o), 192'(m_lat));
    for (int p = 0; p < NP; p++) begin
      wr(p < 32 ? 8'h28 : 8'h2C, 32'd1 << (p % 32));
      m_lat[p] = 1'b0;
      chk(pad_out_o == m_lat, "R5 clear walk", 192'(pad_out_o), 192'(m_lat));
    end
    wr(8'h2C, 32'd0);
    chk(pad_out_o == m_lat, "R5 zero write", 192'(pad_out_o), 192'(m_lat));

    for (int k = 0; k < 40; k++) begin
      int b = k % 2;
      bit s = rnd() > 32'h8000_0000;
      d = rnd();
      wr(8'(s ? (8'h1C + b*4) : (8'h28 + b*4)), d);
      model_setclr(s, b, d);
      chk(pad_out_o == m_lat, s ? "R4 random set" : "R5 random clear", 192'(pad_out_o), 192'(m_lat));
    end

    // R8 unused upper-bank bits
    old = pad_out_o;
    wr(8'h20, 32'hFFC0_0000);
    chk(pad_out_o == old, "R8 set unused bits", 192'(pad_out_o), 192'(old));
    wr(8'h2C, 32'hFFC0_0000);
    chk(pad_out_o == old, "R8 clear unused bits", 192'(pad_out_o), 192'(old));

    // R10 write-only / unmapped / unaligned reads, unmapped writes
    rd(8'h1C, r); chk(r == 0, "R10 read set", 192'(r), 0);
    rd(8'h2C, r); chk(r == 0, "R10 read clear", 192'(r), 0);
    rd(8'h40, r); chk(r == 0, "R10 read unmapped", 192'(r), 0);
    rd(8'h01, r); chk(r == 0, "R10 read unaligned", 192'(r), 0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    chk_pads("R10 unmapped writes");
    chk_words("R10 words after unmapped writes");

    // R11 rdata holds while idle
    rd(8'h00, r);
    repeat (3) @(negedge clk_i);
    chk(rdata_o == r, "R11 hold", 192'(rdata_o), 192'(r));

    // R7 latch kept while input, driven on switch to output
    wr(8'h00, 32'h0);
    model_fsel(0, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);
    model_setclr(0, 0, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h20);
    m_lat[5] = 1'b1;
    chk(pad_oe_o[5] == 1'b0 && pad_out_o[5] == 1'b1, "R7 latch while input",
        192'({pad_oe_o[5], pad_out_o[5]}), 192'(2'b01));
    wr(8'h00, 32'h1 << 15);
    model_fsel(0, 32'h1 << 15);
    chk(pad_oe_o[5] == 1'b1 && pad_out_o[5] == 1'b1, "R7 switch to output",
        192'({pad_oe_o[5], pad_out_o[5]}), 192'(2'b11));
    chk_pads("R7 pads");

    // R9 back-to-back alt -> input -> alt
    wr(8'h00, 32'h4);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = 8'h00; wdata_i = 32'h0;
    @(negedge clk_i);
    chk(pad_oe_o[0] == 0 && pad_func_o[2:0] == 3'd0, "R9 b2b step1",
        192'({pad_oe_o[0], pad_func_o[2:0]}), 192'(4'h0));
    wdata_i = 32'h5;
    @(negedge clk_i); req_i = 0; we_i = 0;
    chk(pad_oe_o[0] == 0 && pad_func_o[2:0] == 3'd5, "R9 b2b step2",
        192'({pad_oe_o[0], pad_func_o[2:0]}), 192'(4'h5));
    // R9 output -> input -> output on consecutive cycles
    wr(8'h00, 32'h1);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = 8'h00; wdata_i = 32'h0;
    @(negedge clk_i);
    chk(pad_oe_o[0] == 0, "R9 b2b out->in", 192'(pad_oe_o[0]), 0);
    wdata_i = 32'h1;
    @(negedge clk_i); req_i = 0; we_i = 0;
    chk(pad_oe_o[0] == 1, "R9 b2b in->out", 192'(pad_oe_o[0]), 1);
    model_fsel(0, 32'h1);
    chk_pads("R9 pads");

    // R6 level reads under mixed functions
    for (int w = 0; w < 6; w++) begin
      d = rnd();
      wr(8'(w*4), d);
      model_fsel(w, d);
    end
    @(negedge clk_i); pad_in_i = '0;
    repeat (3) @(negedge clk_i);
    @(negedge clk_i); pad_in_i = {NP{1'b1}};
    rd(8'h34, r);
    chk(r == 32'h0, "R6 latency old value", 192'(r), 0);
    rd(8'h34, r);
    chk(r == 32'hFFFF_FFFF, "R6 latency new value", 192'(r), 192'(32'hFFFF_FFFF));
    rd(8'h38, r);
    chk(r == 32'h003F_FFFF, "R8 level upper zero", 192'(r), 192'(32'h003F_FFFF));
    for (int k = 0; k < NP + 20; k++) begin
      if (k < NP) v = NP'(1) << k;
      else v = {rnd()[21:0], rnd()};
      @(negedge clk_i); pad_in_i = v;
      @(negedge clk_i);
      rd(8'h34, r);
      chk(r == v[31:0], "R6 level low", 192'(r), 192'(v[31:0]));
      rd(8'h38, r);
      chk(r == {10'd0, v[NP-1:32]}, "R6 level high", 192'(r), 192'({10'd0, v[NP-1:32]}));
    end
    chk_pads("R6 pads unaffected");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule